// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Checker

This block sits at the issue point of a two-wide in-order pipeline. Each cycle fetch presents a window of two consecutive instructions that have already been pre-decoded into a class code and register operand fields. The checker decides whether both issue together, only the first issues, or nothing issues. The first instruction of a pair always goes to the integer slot and the second to the floating-point arithmetic slot. The decision is made in the same cycle the window is presented. The issued instructions appear on registered slot outputs one cycle later.

The window follows a valid/ready discipline in which the `consumed` count takes the place of a one-bit ready. A count of 0 means fetch must hold the window unchanged. A count of 1 means only the first instruction was taken, and fetch must present the second one as the first instruction of the next window. A count of 2 means both were taken. Each execution unit applies back-pressure through its busy input. A busy unit receives nothing in that cycle. In-order rules then decide whether the other slot may still issue.

Each pre-decoded instruction is 25 bits wide. The fields, from the most significant bit down, are:

- bit 24: valid
- bits 23:21: class
- bits 20:14: destination operand
- bits 13:7: source operand B
- bits 6:0: source operand A

Each operand is packed as {enable, fp_file, index[4:0]}. The window places the first instruction in `in_pkt[24:0]` and the second in `in_pkt[49:25]`. The class codes are:

- 0: integer ALU
- 1: integer load
- 2: integer store
- 3: branch
- 4: FP arithmetic
- 5: FP load
- 6: FP store
- 7: FP register move

Top module: `dual_issue_pair`

## Requirements
- R1: During and after reset, `int_v` and `fp_v` are low, and `int_insn` and `fp_insn` are zero, until an instruction issues. `consumed` is 0 while `in_valid` is low.
- R2: Two instructions issue together when all of these hold: the first has class 0 to 3 and no enabled operand with fp_file set; the second is valid with class 4; no RAW hazard exists; and neither unit is busy. Then `consumed` is 2. One cycle later `int_v` and `fp_v` are both high, carrying the first and second instruction respectively.
- R3: An integer-class first instruction issues alone (`consumed` 1, integer slot only) when the second is invalid or has any class other than 4.
- R4: A first instruction that contends for the FP register file issues alone. This covers class 5, 6 or 7, or any enabled operand with fp_file set.
- R5: A RAW hazard breaks the pair. A RAW hazard means the first instruction's destination is enabled and an enabled source of the second has the same fp_file bit and the same index. The same index in different files is not a hazard.
- R6: An FP arithmetic instruction (class 4) in the first position issues alone to the FP slot with `consumed` 1. The second instruction is not issued that cycle.
- R7: With `fp_busy` high, nothing issues to the FP slot. An integer-class first instruction still issues alone. A class-4 first instruction gives `consumed` 0.
- R8: With `int_busy` high and an integer-class first instruction, `consumed` is 0 and neither slot issues, even if the second instruction could go to a free FP unit.
- R9: When `in_valid` is low, or the first instruction's valid bit is low, `consumed` is 0 and neither slot issues, whatever the second half holds.
- R10: A slot whose valid output is low keeps the instruction it last issued on its instruction output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch window present |
| in_pkt | input | 50 | Two pre-decoded instructions, first in the low half |
| int_busy | input | 1 | Integer unit cannot accept this cycle |
| fp_busy | input | 1 | FP unit cannot accept this cycle |
| consumed | output | 2 | Instructions taken from the window this cycle (0, 1 or 2) |
| int_v | output | 1 | Integer slot issued an instruction last cycle |
| int_insn | output | 25 | Instruction held in the integer slot |
| fp_v | output | 1 | FP slot issued an instruction last cycle |
| fp_insn | output | 25 | Instruction held in the FP slot |

## Verification
The hardest situation to reach is a RAW hazard between the two halves. It needs an integer-class writer that touches no FP register, followed by an FP arithmetic reader of an integer register with exactly the same index. Uniformly random fields almost never line up this way. The random stimulus therefore draws register indices from a set of four and sets fp_file bits on the first instruction only rarely. Directed windows add an exact integer-file match and a same-index, different-file near miss.

// File: rtl/dip_pkg.sv
package dip_pkg;
  parameter int REG_IDX_W = 5;
  parameter int CLS_W     = 3;
  parameter int NUM_SRC   = 2;
  parameter int SLOTS     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT_ALU  = 3'd0,
    CLS_INT_LD   = 3'd1,
    CLS_INT_ST   = 3'd2,
    CLS_BRANCH   = 3'd3,
    CLS_FP_ARITH = 3'd4,
    CLS_FP_LD    = 3'd5,
    CLS_FP_ST    = 3'd6,
    CLS_FP_MOV   = 3'd7
  } iclass_e;

  typedef struct packed {
    logic                 en;
    logic                 fp;
    logic [REG_IDX_W-1:0] idx;
  } operand_t;

  typedef struct packed {
    logic                      vld;
    iclass_e                   cls;
    operand_t                  rd;
    operand_t [NUM_SRC-1:0]    src;
  } insn_t;

  localparam int INSN_W = $bits(insn_t);
  localparam int PKT_W  = SLOTS * INSN_W;

  // True when an integer-pipe instruction would need an FP register file port.
  function automatic logic fp_contends(insn_t i);
    logic t;
    t = (i.cls inside {CLS_FP_LD, CLS_FP_ST, CLS_FP_MOV}) || (i.rd.en && i.rd.fp);
    for (int k = 0; k < NUM_SRC; k++) begin
      t = t | (i.src[k].en & i.src[k].fp);
    end
    return t;
  endfunction
endpackage

// File: rtl/dip_raw_check.sv
module dip_raw_check
  import dip_pkg::*;
(
  input  operand_t               producer,
  input  operand_t [NUM_SRC-1:0] consumers,
  output logic                   hit
);
  logic [NUM_SRC-1:0] match;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // Only a register in the same file can carry a dependence.
    assign match[s] = producer.en && consumers[s].en &&
                      (producer.fp == consumers[s].fp) &&
                      (producer.idx == consumers[s].idx);
  end

  assign hit = |match;
endmodule

// File: rtl/dip_issue_ctl.sv
module dip_issue_ctl
  import dip_pkg::*;
(
  input  logic       win_valid,
  input  logic       a_vld,
  input  iclass_e    a_cls,
  input  logic       a_contend,
  input  logic       b_vld,
  input  iclass_e    b_cls,
  input  logic       raw_hit,
  input  logic       int_busy,
  input  logic       fp_busy,
  output logic       take_int,
  output logic       take_fp,
  output logic       fp_from_b,
  output logic [1:0] consumed
);
  logic pair_ok;

  always_comb begin
    pair_ok   = b_vld && (b_cls == CLS_FP_ARITH) && !a_contend && !raw_hit && !fp_busy;
    take_int  = 1'b0;
    take_fp   = 1'b0;
    fp_from_b = 1'b0;
    consumed  = 2'd0;
    if (win_valid && a_vld) begin
      if (a_cls == CLS_FP_ARITH) begin
        // Leftover FP op from a broken pair: it goes out on its own.
        if (!fp_busy) begin
          take_fp  = 1'b1;
          consumed = 2'd1;
        end
      end else if (!int_busy) begin
        take_int = 1'b1;
        consumed = 2'd1;
        if (pair_ok) begin
          take_fp   = 1'b1;
          fp_from_b = 1'b1;
          consumed  = 2'd2;
        end
      end
    end
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PKT_W-1:0]  in_pkt,
  input  logic              int_busy,
  input  logic              fp_busy,
  output logic [1:0]        consumed,
  output logic              int_v,
  output logic [INSN_W-1:0] int_insn,
  output logic              fp_v,
  output logic [INSN_W-1:0] fp_insn
);
  insn_t slot_w [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign slot_w[g] = insn_t'(in_pkt[g*INSN_W +: INSN_W]);
  end

  logic a_contend, raw_hit, take_int, take_fp, fp_from_b;

  assign a_contend = fp_contends(slot_w[0]);

  dip_raw_check u_raw (
    .producer  (slot_w[0].rd),
    .consumers (slot_w[1].src),
    .hit       (raw_hit)
  );

  dip_issue_ctl u_ctl (
    .win_valid (in_valid),
    .a_vld     (slot_w[0].vld),
    .a_cls     (slot_w[0].cls),
    .a_contend (a_contend),
    .b_vld     (slot_w[1].vld),
    .b_cls     (slot_w[1].cls),
    .raw_hit   (raw_hit),
    .int_busy  (int_busy),
    .fp_busy   (fp_busy),
    .take_int  (take_int),
    .take_fp   (take_fp),
    .fp_from_b (fp_from_b),
    .consumed  (consumed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_v    <= 1'b0;
      fp_v     <= 1'b0;
      int_insn <= '0;
      fp_insn  <= '0;
    end else begin
      int_v <= take_int;
      fp_v  <= take_fp;
      if (take_int) int_insn <= slot_w[0];
      if (take_fp)  fp_insn  <= fp_from_b ? slot_w[1] : slot_w[0];
    end
  end

  a_r2_pair_fills_both: assert property (@(posedge clk) disable iff (!rst_n)
    consumed == 2'd2 |=> int_v && fp_v);
  a_r4_contend_alone: assert property (@(posedge clk) disable iff (!rst_n)
    a_contend |-> consumed != 2'd2);
  a_r5_raw_alone: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit |-> consumed != 2'd2);
  a_r7_fp_busy_respected: assert property (@(posedge clk) disable iff (!rst_n)
    fp_busy |=> !fp_v);
  a_r8_int_busy_respected: assert property (@(posedge clk) disable iff (!rst_n)
    int_busy |=> !int_v);
  a_r9_no_window_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !int_v && !fp_v);
  a_r10_int_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !take_int |=> $stable(int_insn));
endmodule

// File: tb/dual_issue_pair_test.sv
module dual_issue_pair_test;
  localparam int W = dip_pkg::INSN_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2*W-1:0] in_pkt = '0;
  logic         int_busy = 1'b0;
  logic         fp_busy = 1'b0;
  logic [1:0]   consumed;
  logic         int_v, fp_v;
  logic [W-1:0] int_insn, fp_insn;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [W-1:0] e_int_insn = '0;
  logic [W-1:0] e_fp_insn = '0;

  always #5 clk = ~clk;

  dual_issue_pair uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .int_busy(int_busy), .fp_busy(fp_busy), .consumed(consumed),
    .int_v(int_v), .int_insn(int_insn), .fp_v(fp_v), .fp_insn(fp_insn)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Layout: {vld, cls[2:0], rd{en,fp,idx}, srcB{en,fp,idx}, srcA{en,fp,idx}}
  function automatic logic [W-1:0] mk(int v, int c, int de, int df, int di,
                                      int be, int bf, int bi, int ae, int af, int ai);
    return {v[0], c[2:0], de[0], df[0], di[4:0], be[0], bf[0], bi[4:0], ae[0], af[0], ai[4:0]};
  endfunction

  function automatic logic [1:0] ref_cons(logic iv, logic [W-1:0] a, logic [W-1:0] b,
                                          logic ib, logic fb);
    logic touch, raw, pair;
    if (!iv || !a[24]) return 2'd0;
    if (a[23:21] == 3'd4) return fb ? 2'd0 : 2'd1;
    if (ib) return 2'd0;
    touch = (a[23:21] >= 3'd5) || (a[20] && a[19]) || (a[13] && a[12]) || (a[6] && a[5]);
    raw = a[20] && ((b[13] && b[12] == a[19] && b[11:7] == a[18:14]) ||
                    (b[6]  && b[5]  == a[19] && b[4:0]  == a[18:14]));
    pair = b[24] && (b[23:21] == 3'd4) && !touch && !raw && !fb;
    return pair ? 2'd2 : 2'd1;
  endfunction

  task automatic step(string req, logic iv, logic [W-1:0] a, logic [W-1:0] b,
                      logic ib, logic fb);
    logic [1:0] ec;
    logic ei, ef;
    @(negedge clk);
    in_valid = iv; in_pkt = {b, a}; int_busy = ib; fp_busy = fb;
    #1;
    ec = ref_cons(iv, a, b, ib, fb);
    chk(consumed == ec, req, "consumed", consumed, ec);
    ei = (ec != 2'd0) && (a[23:21] != 3'd4);
    ef = (ec == 2'd2) || (ec == 2'd1 && a[23:21] == 3'd4);
    if (ei) e_int_insn = a;
    if (ef) e_fp_insn = (ec == 2'd2) ? b : a;
    @(posedge clk);
    #1;
    chk(int_v == ei, req, "int_v", int_v, ei);
    chk(fp_v == ef, req, "fp_v", fp_v, ef);
    chk(int_insn == e_int_insn, req, "int_insn (R10 hold)", int_insn, e_int_insn);
    chk(fp_insn == e_fp_insn, req, "fp_insn (R10 hold)", fp_insn, e_fp_insn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(int_v == 1'b0, "R1", "int_v in reset", int_v, 0);
    chk(fp_v == 1'b0, "R1", "fp_v in reset", fp_v, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(int_v == 1'b0 && fp_v == 1'b0, "R1", "valids after reset", {int_v, fp_v}, 0);
    chk(int_insn == '0 && fp_insn == '0, "R1", "slot contents after reset", int_insn, 0);
    chk(consumed == 2'd0, "R1", "consumed idle", consumed, 0);

    // R2 plain pair: int ALU writes int r3, FP op reads fp r1, r2.
    step("R2", 1, mk(1,0, 1,0,3, 1,0,4, 1,0,5), mk(1,4, 1,1,6, 1,1,1, 1,1,2), 0, 0);
    step("R2", 1, mk(1,3, 0,0,0, 1,0,7, 1,0,8), mk(1,4, 1,1,2, 0,0,0, 1,1,9), 0, 0);
    // R3 second not FP arithmetic, or empty
    step("R3", 1, mk(1,1, 1,0,3, 0,0,0, 1,0,1), mk(1,2, 0,0,0, 1,0,2, 1,0,4), 0, 0);
    step("R3", 1, mk(1,0, 1,0,3, 0,0,0, 1,0,1), mk(0,4, 1,1,1, 1,1,2, 1,1,3), 0, 0);
    // R4 FP-file contention in the first slot
    step("R4", 1, mk(1,5, 1,1,3, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,7, 1,1,8), 0, 0);
    step("R4", 1, mk(1,0, 1,0,3, 1,1,2, 1,0,1), mk(1,4, 1,1,6, 1,1,7, 1,1,8), 0, 0);
    // R5 RAW on int file, then same index but other file
    step("R5", 1, mk(1,0, 1,0,2, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 0,0,0, 1,0,2), 0, 0);
    step("R5", 1, mk(1,0, 1,0,2, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,2, 1,1,2), 0, 0);
    // R6 leftover FP op first
    step("R6", 1, mk(1,4, 1,1,1, 1,1,2, 1,1,3), mk(1,4, 1,1,4, 1,1,5, 1,1,6), 0, 0);
    // R7 FP unit busy
    step("R7", 1, mk(1,0, 1,0,3, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,1, 1,1,2), 0, 1);
    step("R7", 1, mk(1,4, 1,1,1, 1,1,2, 1,1,3), mk(1,4, 1,1,4, 1,1,5, 1,1,6), 0, 1);
    // R8 integer unit busy blocks the whole window
    step("R8", 1, mk(1,0, 1,0,3, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,1, 1,1,2), 1, 0);
    // R9 no window, or invalid first half
    step("R9", 0, mk(1,0, 1,0,3, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,1, 1,1,2), 0, 0);
    step("R9", 1, mk(0,0, 1,0,3, 0,0,0, 1,0,1), mk(1,4, 1,1,6, 1,1,1, 1,1,2), 0, 0);

    for (int n = 0; n < 3000; n++) begin
      int ca, cb;
      ca = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 4);
      cb = ($urandom % 3 == 0) ? int'($urandom % 8) : 4;
      a = mk(($urandom % 10) != 0, ca,
             $urandom % 2, ($urandom % 8) == 0, $urandom % 4,
             $urandom % 2, ($urandom % 8) == 0, $urandom % 4,
             $urandom % 2, ($urandom % 8) == 0, $urandom % 4);
      b = mk(($urandom % 6) != 0, cb,
             $urandom % 2, $urandom % 2, $urandom % 4,
             $urandom % 2, $urandom % 2, $urandom % 4,
             $urandom % 2, $urandom % 2, $urandom % 4);
      step("R2", ($urandom % 8) != 0, a, b, ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule